// File: doc/BRIEF.md
# Multi-phase quad SPI flash sequencer

This block is an SPI master that carries out one complete flash transaction as an ordered list of phases. Each phase has its own configuration slot, so one chip-select frame can hold, for example, a one-line opcode, a four-line address, a few dummy clocks and a four-line data read. Software fills the slots, sets the clock divider and pulses the start input. The engine then walks the slots in ascending order and keeps chip select low from the first phase to the last. When it finishes it releases chip select and raises a done flag, plus an interrupt if that is enabled.

Every phase has four settings: a direction (read or write), a lane width (1, 2 or 4 data lines), a byte count, and a drive bit. When the drive bit is clear on a write phase, that phase only produces dummy clocks. Transmit bytes come in through a valid/ready pair. The serial clock pauses while a byte is not yet available. Received bytes go out with a one-cycle strobe. The whole block runs on one system clock, and SCK is a register bit that toggles after every DIV+1 system clocks.

Top module: `qspi_phase_seq`

## Requirements
- R1: Slot k occupies `cfg_i[21k+20:21k]`. Bit 20 is enable. Bit 19 is direction (1 = read). Bit 18 is drive. Bits 17:16 are the lane code (00 = 1 line, 01 = 2 lines, 10 = 4 lines, 11 = 1 line). Bits 15:0 hold the byte count minus one.
- R2: Phases run in ascending slot order starting at slot 0. The sequence ends after slot NPH-1, or just before the first slot whose enable bit is clear. If slot 0 is disabled, a start sets done at once and chip select stays high.
- R3: `cs_n_o` goes low once per transaction and rises once when all phases are finished. `sck_o` is low whenever `cs_n_o` is high.
- R4: A start pulse is accepted only while `busy_o` is low. A start during a transaction does not change that transaction's clocks or data, and it does not launch another one.
- R5: `done_o` is set when a transaction completes and is cleared by the next accepted start. `irq_o` equals `done_o` AND `irq_en_i`.
- R6: With SCK idle low, each SCK high time is exactly DIV+1 system clocks. Each low time is DIV+1 clocks, longer only while a transmit byte is awaited. The first rise comes DIV+1 clocks after `cs_n_o` falls, and `cs_n_o` rises DIV+1 clocks after the last falling edge.
- R7: A phase with byte-count field n produces (n+1)·8, (n+1)·4 or (n+1)·2 SCK cycles for 1, 2 or 4 lanes.
- R8: In a write phase with drive set, each byte goes out MSB first. On 1 line the bit is on IO0. On 2 lines IO1:IO0 carry two bits per clock. On 4 lines IO3:IO0 carry four bits per clock. Data changes on the falling edge, and `io_oe_o` is 0001, 0011 or 1111 to match.
- R9: In a read phase `io_oe_o` is 0000. Lanes are sampled on the SCK rising edge, MSB first: IO1 on 1 line, IO1:IO0 on 2 lines, IO3:IO0 on 4 lines. Each completed byte appears on `rx_data_o` with a one-cycle `rx_valid_o`.
- R10: A write phase with drive clear keeps `io_oe_o` at 0000 and pulls no transmit bytes. It only produces its SCK cycles.
- R11: `tx_ready_o` is high while a transmit byte for a driven write phase is awaited. Exactly one byte is taken per driven byte, and SCK does not rise while a byte is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | NPH*21 | Phase slots, held stable while busy |
| div_i | input | DIV_W | SCK half-period minus one, in system clocks |
| irq_en_i | input | 1 | Completion interrupt enable |
| start_i | input | 1 | Start request pulse |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmit byte taken when high with valid |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idle low |
| io_i | input | 4 | Data lane inputs IO3..IO0 |
| io_o | output | 4 | Data lane outputs IO3..IO0 |
| io_oe_o | output | 4 | Per-lane output enables |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Completion flag |
| irq_o | output | 1 | Completion interrupt |

## Verification
A wrong phase index or byte counter shows up at the ports within one SCK cycle. The output enables take the wrong lane pattern at the next rising edge, or chip select rises early or late, which changes the total count of SCK rising edges per frame. A shifter off by one lane position shows up as wrong lane values at the rising edge of the first affected beat. On a read it shows up as a wrong byte at the next `rx_valid_o` strobe. A divider fault appears as a high half of the wrong length at the first falling edge after it.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int CNT_W  = 16;
  localparam int SLOT_W = CNT_W + 5;

  typedef struct packed {
    logic             en;
    logic             rd;
    logic             drive;
    logic [1:0]       lanes;
    logic [CNT_W-1:0] nbm1;
  } slot_t;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RUN = 2'd1, S_TAIL = 2'd2} st_e;

  // index of the last beat inside a byte for a lane code
  function automatic logic [2:0] beat_last(input logic [1:0] code);
    case (code)
      2'b01:   return 3'd3;
      2'b10:   return 3'd1;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] code);
    case (code)
      2'b01:   return 4'b0011;
      2'b10:   return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [3:0] out_slice(input logic [7:0] sh, input logic [1:0] code);
    case (code)
      2'b01:   return {2'b00, sh[7:6]};
      2'b10:   return sh[7:4];
      default: return {3'b000, sh[7]};
    endcase
  endfunction

  function automatic logic [7:0] tx_shift(input logic [7:0] sh, input logic [1:0] code);
    case (code)
      2'b01:   return {sh[5:0], 2'b00};
      2'b10:   return {sh[3:0], 4'b0000};
      default: return {sh[6:0], 1'b0};
    endcase
  endfunction

  function automatic logic [7:0] rx_shift(input logic [7:0] r, input logic [3:0] io,
                                          input logic [1:0] code);
    case (code)
      2'b01:   return {r[5:0], io[1:0]};
      2'b10:   return {r[3:0], io};
      default: return {r[6:0], io[1]};
    endcase
  endfunction

  function automatic logic wants_tx(input slot_t s);
    return ~s.rd & s.drive;
  endfunction
endpackage

// File: rtl/qseq_sck_div.sv
module qseq_sck_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] hc_q;
  logic             at_end;

  assign at_end = (hc_q >= div);
  assign tick   = run & at_end & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hc_q <= '0;
    else if (!run || tick)    hc_q <= '0;
    else if (!at_end)         hc_q <= hc_q + DIV_W'(1);
  end
endmodule

// File: rtl/qseq_phase_walker.sv
module qseq_phase_walker
  import qseq_pkg::*;
#(
  parameter int NPH = 8,
  parameter int PIW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  slot_t [NPH-1:0]   slots,
  input  logic              tick,
  input  logic              fall_ev,
  input  logic              tx_fire,
  output st_e               st,
  output logic              cur_rd,
  output logic              cur_drive,
  output logic [1:0]        cur_lanes,
  output logic              last_beat,
  output logic              need,
  output logic              start_acc,
  output logic              done_set
);
  localparam int IDXW = PIW + 1;

  st_e              st_q;
  logic [PIW-1:0]   ph_q;
  logic [CNT_W-1:0] left_q;
  logic [2:0]       beat_q;
  logic             need_q;
  slot_t            cur, nxt;
  logic [IDXW-1:0]  nxt_w;
  logic             nxt_ok;

  assign cur       = slots[ph_q];
  assign nxt_w     = {1'b0, ph_q} + IDXW'(1);
  assign nxt       = slots[nxt_w[PIW-1:0]];
  assign nxt_ok    = (nxt_w < IDXW'(NPH)) && nxt.en;
  assign last_beat = (beat_q == beat_last(cur.lanes));
  assign start_acc = start & (st_q == S_IDLE);
  // R2: a disabled slot 0 completes at once; otherwise completion at end of tail
  assign done_set  = (start_acc & ~slots[0].en) | ((st_q == S_TAIL) & tick);

  assign st        = st_q;
  assign need      = need_q;
  assign cur_rd    = cur.rd;
  assign cur_drive = cur.drive;
  assign cur_lanes = cur.lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ph_q   <= '0;
      left_q <= '0;
      beat_q <= '0;
      need_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start_acc && slots[0].en) begin
            st_q   <= S_RUN;
            ph_q   <= '0;
            left_q <= slots[0].nbm1;
            beat_q <= '0;
            need_q <= wants_tx(slots[0]);
          end
        end
        S_RUN: begin
          if (tx_fire) need_q <= 1'b0;
          if (fall_ev) begin
            if (last_beat) begin
              beat_q <= '0;
              if (left_q == '0) begin
                if (nxt_ok) begin
                  ph_q   <= nxt_w[PIW-1:0];
                  left_q <= nxt.nbm1;
                  need_q <= wants_tx(nxt);
                end else begin
                  st_q <= S_TAIL;
                end
              end else begin
                left_q <= left_q - CNT_W'(1);
                need_q <= wants_tx(cur);
              end
            end else begin
              beat_q <= beat_q + 3'd1;
            end
          end
        end
        S_TAIL: begin
          if (tick) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qseq_lane_shift.sv
module qseq_lane_shift
  import qseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       cur_rd,
  input  logic       cur_drive,
  input  logic [1:0] cur_lanes,
  input  logic       tx_fire,
  input  logic [7:0] tx_data,
  input  logic       rise_ev,
  input  logic       fall_ev,
  input  logic       last_beat,
  input  logic [3:0] io_i,
  output logic [3:0] io_o,
  output logic [3:0] io_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid
);
  logic [7:0] sh_q, rx_q, rx_nxt;

  assign rx_nxt = rx_shift(rx_q, io_i, cur_lanes);
  assign io_o   = out_slice(sh_q, cur_lanes);
  assign io_oe  = (active && !cur_rd && cur_drive) ? lane_mask(cur_lanes) : 4'b0000;

  // transmit side: load on handshake, advance on falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (tx_fire) sh_q <= tx_data;
    else if (fall_ev) sh_q <= tx_shift(sh_q, cur_lanes);
  end

  // receive side: sample on rising edge, strobe a byte on its last beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise_ev && cur_rd) begin
        rx_q <= rx_nxt;
        if (last_beat) begin
          rx_data  <= rx_nxt;
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qspi_phase_seq.sv
module qspi_phase_seq
  import qseq_pkg::*;
#(
  parameter int NPH   = 8,
  parameter int DIV_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPH*SLOT_W-1:0] cfg_i,
  input  logic [DIV_W-1:0]      div_i,
  input  logic                  irq_en_i,
  input  logic                  start_i,
  input  logic [7:0]            tx_data_i,
  input  logic                  tx_valid_i,
  output logic                  tx_ready_o,
  output logic [7:0]            rx_data_o,
  output logic                  rx_valid_o,
  output logic                  cs_n_o,
  output logic                  sck_o,
  input  logic [3:0]            io_i,
  output logic [3:0]            io_o,
  output logic [3:0]            io_oe_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  irq_o
);
  localparam int PIW = $clog2(NPH);

  slot_t [NPH-1:0] slots;
  st_e             st;
  logic            cur_rd, cur_drive, last_beat, need, start_acc, done_set;
  logic [1:0]      cur_lanes;
  logic            tick, rise_ev, fall_ev, tx_fire, in_run, running;
  logic            sck_q, done_q;

  assign slots   = cfg_i;
  assign in_run  = (st == S_RUN);
  assign running = (st != S_IDLE);
  assign tx_fire = tx_ready_o & tx_valid_i;
  assign rise_ev = tick & in_run & ~sck_q;
  assign fall_ev = tick & in_run & sck_q;

  qseq_sck_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .hold  (need & in_run),
    .div   (div_i),
    .tick  (tick)
  );

  qseq_phase_walker #(.NPH(NPH), .PIW(PIW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .slots     (slots),
    .tick      (tick),
    .fall_ev   (fall_ev),
    .tx_fire   (tx_fire),
    .st        (st),
    .cur_rd    (cur_rd),
    .cur_drive (cur_drive),
    .cur_lanes (cur_lanes),
    .last_beat (last_beat),
    .need      (need),
    .start_acc (start_acc),
    .done_set  (done_set)
  );

  qseq_lane_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (in_run),
    .cur_rd    (cur_rd),
    .cur_drive (cur_drive),
    .cur_lanes (cur_lanes),
    .tx_fire   (tx_fire),
    .tx_data   (tx_data_i),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .last_beat (last_beat),
    .io_i      (io_i),
    .io_o      (io_o),
    .io_oe     (io_oe_o),
    .rx_data   (rx_data_o),
    .rx_valid  (rx_valid_o)
  );

  // R6: SCK is a plain register toggled on divider ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sck_q <= 1'b0;
    else if (!in_run) sck_q <= 1'b0;
    else if (tick)    sck_q <= ~sck_q;
  end

  // R5: done flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_q <= 1'b0;
    else if (done_set)  done_q <= 1'b1;
    else if (start_acc) done_q <= 1'b0;
  end

  assign tx_ready_o = in_run & need;
  assign sck_o      = sck_q;
  assign cs_n_o     = ~running;
  assign busy_o     = running;
  assign done_o     = done_q;
  assign irq_o      = done_q & irq_en_i;
endmodule

// File: rtl/qspi_phase_seq_chk.sv
module qspi_phase_seq_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_o,
  input logic             sck_o,
  input logic             irq_o,
  input logic             done_o,
  input logic             busy_o,
  input logic             irq_en_i,
  input logic             tx_ready_o,
  input logic             tx_valid_i,
  input logic             rx_valid_o,
  input logic [3:0]       io_oe_o,
  input logic             fall_ev,
  input logic [DIV_W-1:0] div_i
);
  logic [DIV_W:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_cnt <= '0;
    else if (!sck_o) hi_cnt <= '0;
    else             hi_cnt <= hi_cnt + (DIV_W+1)'(1);
  end

  a_r3_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> !cs_n_o);

  a_r5_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (done_o && irq_en_i));

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r11_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_o && !tx_valid_i && !sck_o) |=> !sck_o);

  a_r9_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r8_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe_o == 4'h0) || (io_oe_o == 4'h1) || (io_oe_o == 4'h3) || (io_oe_o == 4'hF));

  a_r6_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |-> (hi_cnt == {1'b0, div_i}));
endmodule

bind qspi_phase_seq qspi_phase_seq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n_o     (cs_n_o),
  .sck_o      (sck_o),
  .irq_o      (irq_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .irq_en_i   (irq_en_i),
  .tx_ready_o (tx_ready_o),
  .tx_valid_i (tx_valid_i),
  .rx_valid_o (rx_valid_o),
  .io_oe_o    (io_oe_o),
  .fall_ev    (fall_ev),
  .div_i      (div_i)
);

// File: tb/qspi_phase_seq_bench.sv
module qspi_phase_seq_bench;
  import qseq_pkg::*;
  localparam int NPH = 8;
  localparam int DIV_W = 8;
  localparam int MAXB = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  slot_t [NPH-1:0] slots_tb;
  logic [DIV_W-1:0] div_i = '0;
  logic irq_en = 1'b0, start = 1'b0, stall_mode = 1'b0;
  logic [7:0] tx_data, rx_data;
  logic tx_valid, tx_ready, rx_valid, cs_n, sck, busy, done, irq;
  logic [3:0] io_in = 4'h0, io_o, io_oe;

  int total = 0, bad = 0, cyc = 0, tx_idx = 0, rx_cnt = 0, seed = 0;
  logic [7:0] rx_got [4096];
  logic [3:0] exp_oe [MAXB], exp_out [MAXB], in_val [MAXB];
  logic [7:0] exp_rx [MAXB];
  int rises = 0, beat_b = 0, hi_cnt = 0, oe_err = 0, dat_err = 0, hi_err = 0;
  int frame_err = 0, cs_rises = 0, cs_falls = 0, cur_div = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;

  always #2 clk = ~clk;

  qspi_phase_seq #(.NPH(NPH), .DIV_W(DIV_W)) u_qspi_phase_seq (
    .clk(clk), .rst_n(rst_n), .cfg_i(slots_tb), .div_i(div_i), .irq_en_i(irq_en),
    .start_i(start), .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .cs_n_o(cs_n), .sck_o(sck),
    .io_i(io_in), .io_o(io_o), .io_oe_o(io_oe), .busy_o(busy), .done_o(done), .irq_o(irq)
  );

  function automatic logic [7:0] tx_pat(input int i);
    return 8'((i * 71 + 13) ^ (i >> 3));
  endfunction
  function automatic logic [7:0] rd_pat(input int i, input int s);
    return 8'(i * 53 + s * 17 + 5);
  endfunction
  function automatic int lane_w(input logic [1:0] c);
    return (c == 2'b01) ? 2 : (c == 2'b10) ? 4 : 1;
  endfunction

  assign tx_valid = !stall_mode || (cyc % 5 == 2);
  assign tx_data  = tx_pat(tx_idx);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
    if (rx_valid) begin
      rx_got[rx_cnt % 4096] <= rx_data;
      rx_cnt <= rx_cnt + 1;
    end
  end

  // port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (sck && cs_n) frame_err++;
    if (!cs_n && prev_cs) cs_falls++;
    if (cs_n && !prev_cs) cs_rises++;
    if (sck && !prev_sck) begin
      rises++;
      if (beat_b < MAXB) begin
        if (io_oe !== exp_oe[beat_b]) oe_err++;
        if ((io_o & exp_oe[beat_b]) !== (exp_out[beat_b] & exp_oe[beat_b])) dat_err++;
      end
    end
    if (sck) hi_cnt++;
    if (!sck && prev_sck) begin
      if (hi_cnt != cur_div + 1) hi_err++;
      hi_cnt = 0;
      beat_b++;
    end
    io_in = (beat_b < MAXB) ? in_val[beat_b] : 4'h0;
    prev_sck = sck;
    prev_cs  = cs_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_slot(input int k, input bit en, input bit rd, input bit drv,
                          input logic [1:0] ln, input int nbm1);
    slots_tb[k] = '{en: en, rd: rd, drive: drv, lanes: ln, nbm1: CNT_W'(nbm1)};
  endtask

  task automatic clear_slots();
    for (int k = 0; k < NPH; k++) set_slot(k, 1'b0, 1'b0, 1'b0, 2'b00, 0);
  endtask

  task automatic run_txn(input int dv, input bit stl, input bit poke, input bit ien,
                         input string rtag);
    int nb, nw, nr, bpc, msk, guard, tx_base, rx_base, mism;
    logic [7:0] val;
    logic [3:0] sl;
    bit wr;
    nb = 0; nw = 0; nr = 0; seed++;
    for (int p = 0; p < NPH; p++) begin
      if (!slots_tb[p].en) break;
      bpc = lane_w(slots_tb[p].lanes);
      msk = (1 << bpc) - 1;
      wr  = !slots_tb[p].rd && slots_tb[p].drive;
      for (int by = 0; by <= int'(slots_tb[p].nbm1); by++) begin
        if (wr) begin val = tx_pat(tx_idx + nw); nw++; end
        else if (slots_tb[p].rd) begin val = rd_pat(nr, seed); exp_rx[nr] = val; nr++; end
        else val = 8'h00;
        for (int bt = 0; bt < 8 / bpc; bt++) begin
          sl = 4'((int'(val) >> (8 - bpc * (bt + 1))) & msk);
          exp_oe[nb]  = wr ? 4'(msk) : 4'h0;
          exp_out[nb] = sl;
          in_val[nb]  = slots_tb[p].rd ? ((bpc == 1) ? {sl[2:0], 1'b0} : sl) : 4'h0;
          nb++;
        end
      end
    end
    div_i = DIV_W'(dv); cur_div = dv; irq_en = ien; stall_mode = stl;
    rises = 0; beat_b = 0; hi_cnt = 0; oe_err = 0; dat_err = 0; hi_err = 0;
    frame_err = 0; cs_rises = 0; cs_falls = 0;
    tx_base = tx_idx; rx_base = rx_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (12) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 40000) begin @(negedge clk); guard++; end
    chk(guard < 40000, "R5 completion", guard, 40000);
    repeat (3) @(negedge clk);
    chk(rises == nb, {"R7 ", rtag, " sck cycles"}, rises, nb);
    chk(oe_err == 0, "R8 R10 output enables", oe_err, 0);
    chk(dat_err == 0, "R8 lane data", dat_err, 0);
    chk(hi_err == 0, "R6 high time", hi_err, 0);
    chk(frame_err == 0 && cs_falls == (nb > 0 ? 1 : 0) && cs_rises == cs_falls,
        "R3 framing", cs_falls, nb > 0 ? 1 : 0);
    chk(done == 1'b1 && busy == 1'b0, "R5 done", done, 1);
    chk(irq == ien, "R5 irq", irq, ien);
    chk(tx_idx - tx_base == nw, "R11 bytes pulled", tx_idx - tx_base, nw);
    chk(rx_cnt - rx_base == nr, "R9 bytes pushed", rx_cnt - rx_base, nr);
    mism = 0;
    for (int k = 0; k < nr && k < rx_cnt - rx_base; k++)
      if (rx_got[(rx_base + k) % 4096] !== exp_rx[k]) mism++;
    chk(mism == 0, "R9 read bytes", mism, 0);
  endtask

  initial begin
    clear_slots();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(cs_n == 1'b1 && sck == 1'b0, "R3 reset idle", {cs_n, sck}, 2);
    chk(done == 1'b0 && irq == 1'b0 && busy == 1'b0, "R5 reset flags", {done, irq, busy}, 0);
    chk(io_oe == 4'h0 && tx_ready == 1'b0, "R11 reset bus", {tx_ready, io_oe}, 0);

    // sweep: lane code x kind x length x divider
    for (int ln = 0; ln < 4; ln++)
      for (int kind = 0; kind < 3; kind++)
        for (int n = 0; n < 3; n += 2)
          for (int dv = 0; dv < 3; dv += 2) begin
            clear_slots();
            set_slot(0, 1'b1, kind == 1, kind == 0, 2'(ln), n);
            run_txn(dv, (ln + n) % 2 == 1, 1'b0, kind == 2, kind == 2 ? "R10" : "R7");
          end

    // full eight-phase frame (R1 slot layout, R2 order)
    clear_slots();
    set_slot(0, 1'b1, 1'b0, 1'b1, 2'b00, 0);
    set_slot(1, 1'b1, 1'b0, 1'b1, 2'b10, 2);
    set_slot(2, 1'b1, 1'b0, 1'b0, 2'b10, 1);
    set_slot(3, 1'b1, 1'b1, 1'b0, 2'b10, 3);
    set_slot(4, 1'b1, 1'b0, 1'b1, 2'b01, 1);
    set_slot(5, 1'b1, 1'b1, 1'b0, 2'b01, 1);
    set_slot(6, 1'b1, 1'b1, 1'b0, 2'b00, 1);
    set_slot(7, 1'b1, 1'b0, 1'b1, 2'b00, 0);
    run_txn(1, 1'b1, 1'b0, 1'b1, "R1");
    run_txn(0, 1'b0, 1'b0, 1'b1, "R2");

    // start while busy is ignored
    run_txn(3, 1'b0, 1'b1, 1'b0, "R4");
    cs_falls = 0;
    repeat (20) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0 && cs_falls == 0, "R4 no relaunch", cs_falls, 0);

    // early end at a disabled slot
    set_slot(3, 1'b0, 1'b1, 1'b0, 2'b10, 3);
    run_txn(2, 1'b1, 1'b0, 1'b0, "R2");

    // slot 0 disabled
    set_slot(0, 1'b0, 1'b0, 1'b1, 2'b00, 0);
    run_txn(1, 1'b0, 1'b0, 1'b1, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc == 180000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule